// File: doc/BRIEF.md
# System-Control Register Bank

This block holds the system-control registers of a processor core: translation set-up registers, a cycle counter with a compare value, a replacement pointer, status and cause words, exception return addresses, configuration words, watch registers, debug state and a cache tag word. Software addresses a register by a 5-bit number and a 3-bit select. Each register applies its own writable-bit mask on a write, and some registers also keep part of the stored value.

Four mode flags (user mode, exception level, error level, debug mode) are kept as separate state and leave the block as outputs. Reads of Status and Debug merge these flags back into the returned word. Six external hardware interrupt lines are sampled into the cause word on every clock edge. A Status write that enables interrupts while an interrupt is already pending raises a hard-interrupt request. A later Status write that disables interrupts withdraws it.

Reads are combinational and take effect in the same cycle. Writes take effect at the next rising clock edge. The reset is asynchronous and active low.

Top module: `cp0_regbank`

## Requirements
- R1: After reset every register reads zero, with three exceptions: Random (register 1) reads 15, Config (16, select 0) reads the parameter CFG0_RST, and PRid (15) reads PRID_VAL. All four mode flags and the interrupt request are 0.
- R2: A write with a nonzero select changes no register. A read with a nonzero select returns zero, except register 16 select 1 (returns CFG1_VAL) and register 28 select 1 (returns zero).
- R3: Writes with select 0 store the following masked values. Index (0) and Wired (6) keep wr_data[3:0]. EntryLo0 and EntryLo1 (2, 3) keep wr_data & 0x3FFFFFFF. PageMask (5) keeps wr_data & 0x01FFE000. EntryHi (10) keeps wr_data & 0xFFFFF0FF. WatchHi (19) keeps wr_data & 0x40FF0FF8. TagLo (28) keeps wr_data & 0xFFFFFCF6. Context (4) replaces only bits 23:4 and keeps its stored bits 31:24. Registers 11, 14, 18, 24, 30 and 31 store the full 32 bits.
- R4: A Status (12) write stores wr_data & 0xFA78FF01. It also sets the user flag from bit 4, the error-level flag from bit 2 and the exception-level flag from bit 1. A Status read returns the stored word ORed with these flags at bits 4, 2 and 1.
- R5: A Cause (13) write computes (old & 0xB000F87C) | (wr_data & 0x00C00300). Bits 15:10 always load hw_pend_i at each rising edge, which overrides any value from a write.
- R6: A Status write raises irq_req_o at the next edge when all of the following hold: the written bit 0 is 1, the stored bit 0 was 0, the written bits 1 and 2 are 0, the debug flag is 0, and the stored Cause bits 15:10 are not all zero.
- R7: A Status write that clears bit 0 while the stored bit 0 is 1 drops irq_req_o at the next edge. Any other Status write that does not meet the R6 condition leaves irq_req_o unchanged.
- R8: A Debug (23) write computes (old & 0x8C03FC1F) | (wr_data & 0x13300120) and sets the debug flag from wr_data[30]. A Debug read ORs the debug flag in at bit 30.
- R9: A write to register 17 stores the address. A read of register 17 returns that address shifted right by 4.
- R10: Count (9) increments by one at each edge, and a write loads it instead. Random (1) is read-only. At each edge it reloads 15 if it is at or below the stored Wired value, and otherwise decrements by one.
- R11: Registers 7, 8, 20 to 22, 25 to 27 and 29 read zero, and writes to them have no effect.
- R12: A Config (16, select 0) write computes (old & 0xFE17FF80) | (wr_data & 1). Config select 1 and PRid are constants that writes do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_reg | input | 5 | Write register number |
| wr_sel | input | 3 | Write select |
| wr_data | input | 32 | Write data |
| rd_reg | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Read data, combinational |
| hw_pend_i | input | 6 | External interrupt pending lines |
| user_mode_o | output | 1 | User-mode flag |
| exc_lvl_o | output | 1 | Exception-level flag |
| err_lvl_o | output | 1 | Error-level flag |
| debug_mode_o | output | 1 | Debug-mode flag |
| irq_req_o | output | 1 | Hard-interrupt request |

## Verification
A write is visible on rd_data and on the flag outputs from the cycle after its rising edge, and the interrupt request changes at that same edge. A change on hw_pend_i reaches Cause bits 15:10 one edge later, while Count and Random move once per edge. The bench drives every input at the falling edge and compares rd_data, the flags and the request 1 ns later against its model. It then advances the model exactly once at the rising edge, so each result is sampled in the first cycle it is due.

// File: rtl/cp0_regbank.sv
module cp0_regbank #(
  parameter logic [31:0] PRID_VAL = 32'h0000_0400,
  parameter logic [31:0] CFG0_RST = 32'h8000_0080,
  parameter logic [31:0] CFG1_VAL = 32'h1E19_0C8A,
  parameter logic [3:0]  RAND_TOP = 4'd15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_reg,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_reg,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic [5:0]  hw_pend_i,
  output logic        user_mode_o,
  output logic        exc_lvl_o,
  output logic        err_lvl_o,
  output logic        debug_mode_o,
  output logic        irq_req_o
);

  localparam logic [31:0] M_LO     = 32'h3FFF_FFFF;
  localparam logic [31:0] M_CTX    = 32'h00FF_FFF0;
  localparam logic [31:0] M_PGM    = 32'h01FF_E000;
  localparam logic [31:0] M_HI     = 32'hFFFF_F0FF;
  localparam logic [31:0] M_ST     = 32'hFA78_FF01;
  localparam logic [31:0] M_CA_K   = 32'hB000_F87C;
  localparam logic [31:0] M_CA_S   = 32'h00C0_0300;
  localparam logic [31:0] M_PEND   = 32'h0000_FC00;
  localparam logic [31:0] M_CF_K   = 32'hFE17_FF80;
  localparam logic [31:0] M_WHI    = 32'h40FF_0FF8;
  localparam logic [31:0] M_DB_K   = 32'h8C03_FC1F;
  localparam logic [31:0] M_DB_S   = 32'h1330_0120;
  localparam logic [31:0] M_TAG    = 32'hFFFF_FCF6;

  logic [3:0]  idx_q, wired_q, rand_q;
  logic [31:0] lo0_q, lo1_q, ctx_q, pgm_q, cnt_q, hi_q, cmp_q;
  logic [31:0] st_q, ca_q, epc_q, cfg0_q, wlo_q, whi_q;
  logic [31:0] dbg_q, depc_q, tag_q, eepc_q, dsave_q;
  logic [27:0] ll_q;
  logic        um_q, erl_q, exl_q, dm_q, irq_q;

  logic        w0, w_st, w_ca, w_cnt, w_dbg;
  logic        irq_set, irq_clr;
  logic [31:0] ca_nx;

  assign w0    = wr_en && (wr_sel == 3'd0);
  assign w_st  = w0 && (wr_reg == 5'd12);
  assign w_ca  = w0 && (wr_reg == 5'd13);
  assign w_cnt = w0 && (wr_reg == 5'd9);
  assign w_dbg = w0 && (wr_reg == 5'd23);

  assign irq_set = w_st && wr_data[0] && !st_q[0] && !wr_data[1] && !wr_data[2]
                   && !dm_q && (|ca_q[15:10]);
  assign irq_clr = w_st && !wr_data[0] && st_q[0];

  assign ca_nx = w_ca ? ((ca_q & M_CA_K) | (wr_data & M_CA_S)) : ca_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      wired_q <= '0;
      rand_q  <= RAND_TOP;
      lo0_q   <= '0;
      lo1_q   <= '0;
      ctx_q   <= '0;
      pgm_q   <= '0;
      cnt_q   <= '0;
      hi_q    <= '0;
      cmp_q   <= '0;
      st_q    <= '0;
      ca_q    <= '0;
      epc_q   <= '0;
      cfg0_q  <= CFG0_RST;
      ll_q    <= '0;
      wlo_q   <= '0;
      whi_q   <= '0;
      dbg_q   <= '0;
      depc_q  <= '0;
      tag_q   <= '0;
      eepc_q  <= '0;
      dsave_q <= '0;
      um_q    <= 1'b0;
      erl_q   <= 1'b0;
      exl_q   <= 1'b0;
      dm_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q  <= w_cnt ? wr_data : cnt_q + 32'd1;
      rand_q <= (rand_q <= wired_q) ? RAND_TOP : rand_q - 4'd1;
      ca_q   <= (ca_nx & ~M_PEND) | {16'd0, hw_pend_i, 10'd0};
      if (w0) begin
        case (wr_reg)
          5'd0:  idx_q   <= wr_data[3:0];
          5'd2:  lo0_q   <= wr_data & M_LO;
          5'd3:  lo1_q   <= wr_data & M_LO;
          5'd4:  ctx_q   <= (ctx_q & ~M_CTX) | (wr_data & M_CTX);
          5'd5:  pgm_q   <= wr_data & M_PGM;
          5'd6:  wired_q <= wr_data[3:0];
          5'd10: hi_q    <= wr_data & M_HI;
          5'd11: cmp_q   <= wr_data;
          5'd12: begin
            st_q  <= wr_data & M_ST;
            um_q  <= wr_data[4];
            erl_q <= wr_data[2];
            exl_q <= wr_data[1];
            if (irq_set)      irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
          end
          5'd14: epc_q   <= wr_data;
          5'd16: cfg0_q  <= (cfg0_q & M_CF_K) | {31'd0, wr_data[0]};
          5'd17: ll_q    <= wr_data[31:4];
          5'd18: wlo_q   <= wr_data;
          5'd19: whi_q   <= wr_data & M_WHI;
          5'd23: begin
            dbg_q <= (dbg_q & M_DB_K) | (wr_data & M_DB_S);
            dm_q  <= wr_data[30];
          end
          5'd24: depc_q  <= wr_data;
          5'd28: tag_q   <= wr_data & M_TAG;
          5'd30: eepc_q  <= wr_data;
          5'd31: dsave_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_sel == 3'd0 || rd_reg == 5'd16 || rd_reg == 5'd28) begin
      case (rd_reg)
        5'd0:  rd_data = {28'd0, idx_q};
        5'd1:  rd_data = {28'd0, rand_q};
        5'd2:  rd_data = lo0_q;
        5'd3:  rd_data = lo1_q;
        5'd4:  rd_data = ctx_q;
        5'd5:  rd_data = pgm_q;
        5'd6:  rd_data = {28'd0, wired_q};
        5'd9:  rd_data = cnt_q;
        5'd10: rd_data = hi_q;
        5'd11: rd_data = cmp_q;
        5'd12: rd_data = st_q | {27'd0, um_q, 1'b0, erl_q, exl_q, 1'b0};
        5'd13: rd_data = ca_q;
        5'd14: rd_data = epc_q;
        5'd15: rd_data = PRID_VAL;
        5'd16: begin
          if (rd_sel == 3'd0)      rd_data = cfg0_q;
          else if (rd_sel == 3'd1) rd_data = CFG1_VAL;
        end
        5'd17: rd_data = {4'd0, ll_q};
        5'd18: rd_data = wlo_q;
        5'd19: rd_data = whi_q;
        5'd23: rd_data = dbg_q | {1'b0, dm_q, 30'd0};
        5'd24: rd_data = depc_q;
        5'd28: begin
          if (rd_sel == 3'd0) rd_data = tag_q;
        end
        5'd30: rd_data = eepc_q;
        5'd31: rd_data = dsave_q;
        default: rd_data = '0;
      endcase
    end
  end

  assign user_mode_o  = um_q;
  assign exc_lvl_o    = exl_q;
  assign err_lvl_o    = erl_q;
  assign debug_mode_o = dm_q;
  assign irq_req_o    = irq_q;

  a_r2_badsel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != 3'd0 && wr_reg == 5'd14) |=> $stable(epc_q));

  a_r3_index_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && wr_reg == 5'd0) |=> (idx_q == $past(wr_data[3:0])));

  a_r4_user_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && wr_reg == 5'd12) |=> (user_mode_o == $past(wr_data[4])));

  a_r6_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && wr_reg == 5'd12 && wr_data[0] && !wr_data[1] && !wr_data[2]
     && !st_q[0] && !debug_mode_o && (|ca_q[15:10])) |=> irq_req_o);

  a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && wr_reg == 5'd12 && !wr_data[0] && st_q[0]) |=> !irq_req_o);

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd0 && wr_reg == 5'd12) |=> $stable(irq_req_o));

  a_r8_debug_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && wr_reg == 5'd23) |=> (debug_mode_o == $past(wr_data[30])));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd0 && wr_reg == 5'd9) |=> (cnt_q == $past(cnt_q) + 32'd1));

  a_r5_pending_sampled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ca_q[15:10] == $past(hw_pend_i)));

endmodule

// File: tb/cp0_regbank_tb.sv
module cp0_regbank_tb_top;
  localparam logic [31:0] PRID = 32'h0000_0400;
  localparam logic [31:0] CFG0 = 32'h8000_0080;
  localparam logic [31:0] CFG1 = 32'h1E19_0C8A;
  localparam logic [3:0]  RTOP = 4'd15;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, wr_en;
  logic [4:0]  wr_reg, rd_reg;
  logic [2:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic [5:0]  pend;
  logic        um, exl, erl, dm, irq;

  cp0_regbank #(.PRID_VAL(PRID), .CFG0_RST(CFG0), .CFG1_VAL(CFG1), .RAND_TOP(RTOP)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_reg(rd_reg), .rd_sel(rd_sel), .rd_data(rd_data),
    .hw_pend_i(pend), .user_mode_o(um), .exc_lvl_o(exl), .err_lvl_o(erl),
    .debug_mode_o(dm), .irq_req_o(irq));

  logic [31:0] m [32];
  logic [3:0]  m_rand;
  logic        m_um, m_erl, m_exl, m_dm, m_irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  function automatic logic [31:0] mread(input logic [4:0] r, input logic [2:0] s);
    if (s != 3'd0 && r != 5'd16 && r != 5'd28) return 32'd0;
    case (r)
      5'd1:  return {28'd0, m_rand};
      5'd12: return m[12] | (32'(m_um) << 4) | (32'(m_erl) << 2) | (32'(m_exl) << 1);
      5'd15: return PRID;
      5'd16: return (s == 3'd0) ? m[16] : ((s == 3'd1) ? CFG1 : 32'd0);
      5'd17: return m[17] >> 4;
      5'd23: return m[23] | (32'(m_dm) << 30);
      5'd28: return (s == 3'd0) ? m[28] : 32'd0;
      default: return m[r];
    endcase
  endfunction

  task automatic model_edge(input bit we, input logic [4:0] r, input logic [2:0] s,
                            input logic [31:0] d);
    logic [31:0] old_st, old_ca, old_w;
    bit w0;
    old_st = m[12];
    old_ca = m[13];
    old_w  = m[6];
    w0 = we && (s == 3'd0);
    m[9] = (w0 && r == 5'd9) ? d : m[9] + 32'd1;
    m_rand = (m_rand <= old_w[3:0]) ? RTOP : m_rand - 4'd1;
    if (w0) begin
      case (r)
        5'd0, 5'd6: m[r] = {28'd0, d[3:0]};
        5'd2, 5'd3: m[r] = d & 32'h3FFF_FFFF;
        5'd4:  m[4] = (m[4] & 32'hFF00_0000) | (d & 32'h00FF_FFF0);
        5'd5:  m[5] = d & 32'h01FF_E000;
        5'd10: m[10] = d & 32'hFFFF_F0FF;
        5'd11, 5'd14, 5'd17, 5'd18, 5'd24, 5'd30, 5'd31: m[r] = d;
        5'd12: begin
          m[12] = d & 32'hFA78_FF01;
          m_um = d[4]; m_erl = d[2]; m_exl = d[1];
          if (d[0] && !old_st[0] && !d[1] && !d[2] && !m_dm && old_ca[15:10] != 6'd0)
            m_irq = 1'b1;
          else if (!d[0] && old_st[0])
            m_irq = 1'b0;
        end
        5'd13: m[13] = (old_ca & 32'hB000_F87C) | (d & 32'h00C0_0300);
        5'd16: m[16] = (m[16] & 32'hFE17_FF80) | (d & 32'd1);
        5'd19: m[19] = d & 32'h40FF_0FF8;
        5'd23: begin
          m[23] = (m[23] & 32'h8C03_FC1F) | (d & 32'h1330_0120);
          m_dm = d[30];
        end
        5'd28: m[28] = d & 32'hFFFF_FCF6;
        default: ;
      endcase
    end
    m[13][15:10] = pend;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit we, input logic [4:0] wr, input logic [2:0] ws,
                      input logic [31:0] wd, input logic [4:0] rr, input logic [2:0] rs,
                      input string tag);
    wr_en = we; wr_reg = wr; wr_sel = ws; wr_data = wd; rd_reg = rr; rd_sel = rs;
    #1;
    chk(tag, rd_data, mread(rr, rs));
    chk(tag, {27'd0, um, erl, exl, dm, irq}, {27'd0, m_um, m_erl, m_exl, m_dm, m_irq});
    @(posedge clk);
    model_edge(we, wr, ws, wd);
    @(negedge clk);
  endtask

  task automatic wr_rd(input logic [4:0] r, input logic [2:0] s, input logic [31:0] d,
                       input string tag);
    step(1'b1, r, s, d, r, s, tag);
    step(1'b0, 5'd0, 3'd0, 32'd0, r, s, tag);
  endtask

  task automatic rd(input logic [4:0] r, input logic [2:0] s, input string tag);
    step(1'b0, 5'd0, 3'd0, 32'd0, r, s, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int regs3[15] = '{0, 2, 3, 4, 5, 6, 10, 11, 14, 18, 19, 24, 28, 30, 31};
    int regs11[8] = '{7, 8, 20, 21, 22, 25, 27, 29};
    rst_n = 1'b0; wr_en = 1'b0; wr_reg = '0; wr_sel = '0; wr_data = '0;
    rd_reg = '0; rd_sel = '0; pend = '0;
    for (int i = 0; i < 32; i++) m[i] = 32'd0;
    m[16] = CFG0; m_rand = RTOP;
    m_um = 1'b0; m_erl = 1'b0; m_exl = 1'b0; m_dm = 1'b0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", rd_data, 32'd0);
    chk("R1", {27'd0, um, erl, exl, dm, irq}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < 32; r++) rd(5'(r), 3'd0, "R1");

    for (int i = 0; i < 15; i++) begin
      wr_rd(5'(regs3[i]), 3'd0, 32'hFFFF_FFFF, "R3");
      wr_rd(5'(regs3[i]), 3'd0, 32'h5A5A_A5A5, "R3");
    end

    wr_rd(5'd14, 3'd3, 32'h0000_1234, "R2");
    rd(5'd14, 3'd2, "R2");
    wr_rd(5'd16, 3'd1, 32'hFFFF_FFFF, "R2");
    rd(5'd16, 3'd2, "R2");
    wr_rd(5'd28, 3'd1, 32'hFFFF_FFFF, "R2");
    wr_rd(5'd12, 3'd5, 32'hFFFF_FFFF, "R2");

    wr_rd(5'd16, 3'd0, 32'hFFFF_FFFF, "R12");
    wr_rd(5'd16, 3'd0, 32'h0000_0000, "R12");
    wr_rd(5'd15, 3'd0, 32'hDEAD_BEEF, "R12");

    for (int i = 0; i < 8; i++) wr_rd(5'(regs11[i]), 3'd0, 32'hFFFF_FFFF, "R11");

    wr_rd(5'd17, 3'd0, 32'h1234_5678, "R9");
    wr_rd(5'd17, 3'd0, 32'hFFFF_FFFF, "R9");

    wr_rd(5'd9, 3'd0, 32'hFFFF_FFFE, "R10");
    for (int i = 0; i < 4; i++) rd(5'd9, 3'd0, "R10");
    wr_rd(5'd1, 3'd0, 32'h0000_0003, "R10");
    for (int i = 0; i < 20; i++) rd(5'd1, 3'd0, "R10");
    wr_rd(5'd6, 3'd0, 32'h0000_000C, "R10");
    for (int i = 0; i < 10; i++) rd(5'd1, 3'd0, "R10");
    wr_rd(5'd6, 3'd0, 32'h0000_000F, "R10");
    for (int i = 0; i < 4; i++) rd(5'd1, 3'd0, "R10");

    wr_rd(5'd12, 3'd0, 32'hFFFF_FFFF, "R4");
    wr_rd(5'd12, 3'd0, 32'h0000_0012, "R4");
    wr_rd(5'd12, 3'd0, 32'h0000_0004, "R4");
    wr_rd(5'd12, 3'd0, 32'h0000_0000, "R4");

    pend = 6'b101001;
    wr_rd(5'd13, 3'd0, 32'hFFFF_FFFF, "R5");
    pend = 6'b000000;
    wr_rd(5'd13, 3'd0, 32'h0000_0000, "R5");
    rd(5'd13, 3'd0, "R5");

    pend = 6'b000001;
    rd(5'd13, 3'd0, "R6");
    wr_rd(5'd12, 3'd0, 32'h0000_0001, "R6");
    wr_rd(5'd12, 3'd0, 32'h0000_8001, "R7");
    wr_rd(5'd12, 3'd0, 32'h0000_0000, "R7");
    wr_rd(5'd12, 3'd0, 32'h0000_0003, "R6");
    wr_rd(5'd12, 3'd0, 32'h0000_0000, "R6");
    wr_rd(5'd12, 3'd0, 32'h0000_0005, "R6");
    wr_rd(5'd12, 3'd0, 32'h0000_0000, "R6");
    pend = 6'b000000;
    rd(5'd13, 3'd0, "R6");
    wr_rd(5'd12, 3'd0, 32'h0000_0001, "R6");
    wr_rd(5'd12, 3'd0, 32'h0000_0000, "R7");
    pend = 6'b100000;
    rd(5'd12, 3'd0, "R6");
    wr_rd(5'd12, 3'd0, 32'h0000_0001, "R6");
    pend = 6'b000000;
    wr_rd(5'd13, 3'd0, 32'h0000_0000, "R7");
    wr_rd(5'd12, 3'd0, 32'h0000_0000, "R7");

    wr_rd(5'd23, 3'd0, 32'hFFFF_FFFF, "R8");
    pend = 6'b000010;
    rd(5'd23, 3'd0, "R8");
    wr_rd(5'd12, 3'd0, 32'h0000_0001, "R8");
    wr_rd(5'd12, 3'd0, 32'h0000_0000, "R8");
    wr_rd(5'd23, 3'd0, 32'h4000_0000, "R8");
    wr_rd(5'd23, 3'd0, 32'h0000_0000, "R8");
    pend = 6'b000000;
    rd(5'd13, 3'd0, "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule